// File: doc/BRIEF.md
# Redundancy Mode and Recovery Sequencer

This controller steers a processor that runs a protected program on three hardware thread contexts. Two of them, the leading and trailing contexts, always run the protected program. The third, the spare context, either runs an unrelated job of its own (paired mode) or runs as a third copy of the protected program (voting mode). The sequencer decides which mode is active. It reacts to mismatch and persistent-fault indications from the result checker, and it walks the contexts through each recovery path by raising command levels and waiting for a completion handshake.

In paired mode, a mismatch makes the sequencer park the spare job, copy the committed state, re-run the instruction while the pair recovers, and then release everything. A persistent fault in paired mode hands the protected program to the spare while the pair tests itself. In voting mode, a persistent fault halts all three contexts so the spare can verify its private resources. What follows depends on the result of that check. The sequencer also keeps a usable flag for each functional unit, which the scheduler reads. The flags are written by self-test result strobes.

Top module: `redund_mode_ctrl`

## Requirements
- R1: After reset, paired mode is active (mode_triple=0), every command output and err are 0, and unit_usable is all ones.
- R2: In paired running, arb_req starts the mismatch path: halt_job alone, then halt_job+copy_state, then halt_job+reexec+lt_recover, then resume. Each step advances on the clock edge where phase_done is sampled high.
- R3: In paired running, perm_fault raises halt_job+arb_takeover+lt_selftest. On phase_done, the sequencer goes to resume and then returns to paired running.
- R4: In voting running, perm_fault raises halt_all+arb_selfver. On phase_done with selfver_pass=1 it moves to arb_takeover+lt_selftest, then on phase_done to resume, then back to voting running with mode_triple=1 throughout.
- R5: In the voting verify phase, phase_done with selfver_pass=0 goes straight to resume and then to voting running.
- R6: arb_req has no effect in voting mode, and halt_job, copy_state and reexec stay 0 there.
- R7: A mode switch (mode_sw_req with mode_sw_to_triple giving the target, 1=voting) takes effect at the next edge, and only from a running state. A request made inside any recovery phase is dropped.
- R8: If phase_done stays low for TIMEOUT_CYC cycles of a waiting phase, the sequencer enters a fault state. In that state err=1, all commands are 0, and the state holds until reset. A phase_done on the last allowed cycle still advances.
- R9: While halt_job+arb_takeover, halt_all+arb_selfver or arb_takeover+lt_selftest is active, a st_res_valid strobe sets unit_usable[st_res_unit] to !st_res_bad at the next edge. Strobes at any other time are ignored.
- R10: When perm_fault and arb_req arrive together in paired running, the persistent-fault path wins. Both of them win over a mode switch.
- R11: resume is high for exactly one cycle per recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sw_req | input | 1 | Mode switch request |
| mode_sw_to_triple | input | 1 | Switch target, 1 = voting, 0 = paired |
| arb_req | input | 1 | Mismatch from the pair, needs arbitration |
| perm_fault | input | 1 | Repeated-failure (persistent fault) flag |
| phase_done | input | 1 | Completion handshake for the current phase |
| selfver_pass | input | 1 | Spare self-verification result, valid with phase_done |
| st_res_valid | input | 1 | Self-test result strobe |
| st_res_unit | input | UIDX_W | Functional unit index of the result |
| st_res_bad | input | 1 | Unit failed its test |
| mode_triple | output | 1 | Voting mode active |
| halt_job | output | 1 | Spare context's own job parked |
| halt_all | output | 1 | All three contexts stopped |
| copy_state | output | 1 | Copy committed PC and registers to spare |
| reexec | output | 1 | Spare re-runs the faulting instruction |
| lt_recover | output | 1 | Pair performs self-recovery |
| lt_selftest | output | 1 | Pair runs its self-test |
| arb_selfver | output | 1 | Spare verifies its private resources |
| arb_takeover | output | 1 | Spare runs and commits the protected program |
| resume | output | 1 | One-cycle release back to normal roles |
| err | output | 1 | Handshake timeout, sticky until reset |
| unit_usable | output | N_UNITS | Per-unit usable flags for the scheduler |

## Verification
The bench varies how long each phase waits before its handshake. This catches a sequencer that skips a step or advances without phase_done. The self-verify outcome is driven both ways, so a design that always enters the pair self-check, or never does, shows up. Every unit index is marked failed and then restored inside a test window. A strobe outside a window is also checked, which exposes a table that writes at any time or decodes the wrong index. The timeout is probed with a handshake on the very last allowed cycle and with no handshake at all, which exposes an off-by-one counter. The bench also checks that mode switches requested mid-recovery are dropped and that perm_fault beats arb_req.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

  typedef enum logic [3:0] {
    ST_D_RUN,
    ST_D_HALT,
    ST_D_COPY,
    ST_D_REEXEC,
    ST_D_TAKE,
    ST_D_RESUME,
    ST_T_RUN,
    ST_T_VERIFY,
    ST_T_CHECK,
    ST_T_RESUME,
    ST_FAULT
  } rmc_state_e;

  typedef struct packed {
    logic halt_job;
    logic halt_all;
    logic copy_state;
    logic reexec;
    logic lt_recover;
    logic lt_selftest;
    logic arb_selfver;
    logic arb_takeover;
    logic resume;
    logic err;
  } rmc_cmd_t;

  function automatic rmc_cmd_t cmd_of(rmc_state_e s);
    rmc_cmd_t c;
    c = '0;
    case (s)
      ST_D_HALT:   c.halt_job = 1'b1;
      ST_D_COPY:   begin c.halt_job = 1'b1; c.copy_state = 1'b1; end
      ST_D_REEXEC: begin c.halt_job = 1'b1; c.reexec = 1'b1; c.lt_recover = 1'b1; end
      ST_D_TAKE:   begin c.halt_job = 1'b1; c.arb_takeover = 1'b1; c.lt_selftest = 1'b1; end
      ST_T_VERIFY: begin c.halt_all = 1'b1; c.arb_selfver = 1'b1; end
      ST_T_CHECK:  begin c.arb_takeover = 1'b1; c.lt_selftest = 1'b1; end
      ST_D_RESUME, ST_T_RESUME: c.resume = 1'b1;
      ST_FAULT:    c.err = 1'b1;
      default:     c = '0;
    endcase
    return c;
  endfunction

  // phases that wait on the completion handshake
  function automatic logic is_waiting(rmc_state_e s);
    return (s == ST_D_HALT) || (s == ST_D_COPY) || (s == ST_D_REEXEC) ||
           (s == ST_D_TAKE) || (s == ST_T_VERIFY) || (s == ST_T_CHECK);
  endfunction

  // phases in which self-test results may update the unit table
  function automatic logic is_test_window(rmc_state_e s);
    return (s == ST_D_TAKE) || (s == ST_T_VERIFY) || (s == ST_T_CHECK);
  endfunction

  function automatic logic is_voting(rmc_state_e s);
    return (s == ST_T_RUN) || (s == ST_T_VERIFY) || (s == ST_T_CHECK) ||
           (s == ST_T_RESUME);
  endfunction

endpackage

// File: rtl/rmc_phase_timer.sv
module rmc_phase_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic active,
  output logic expired
);
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !active) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = active && (cnt_q == LAST);
endmodule

// File: rtl/rmc_unit_table.sv
module rmc_unit_table #(
  parameter int N_UNITS = 8,
  parameter int UIDX_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [UIDX_W-1:0]  wr_idx,
  input  logic               wr_bad,
  output logic [N_UNITS-1:0] usable
);
  for (genvar g = 0; g < N_UNITS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        usable[g] <= 1'b1;
      end else if (wr_en && (wr_idx == UIDX_W'(g))) begin
        usable[g] <= !wr_bad;
      end
    end
  end
endmodule

// File: rtl/redund_mode_ctrl.sv
module redund_mode_ctrl
  import rmc_pkg::*;
#(
  parameter int N_UNITS     = 8,
  parameter int TIMEOUT_CYC = 256,
  parameter int UIDX_W      = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_sw_req,
  input  logic               mode_sw_to_triple,
  input  logic               arb_req,
  input  logic               perm_fault,
  input  logic               phase_done,
  input  logic               selfver_pass,
  input  logic               st_res_valid,
  input  logic [UIDX_W-1:0]  st_res_unit,
  input  logic               st_res_bad,
  output logic               mode_triple,
  output logic               halt_job,
  output logic               halt_all,
  output logic               copy_state,
  output logic               reexec,
  output logic               lt_recover,
  output logic               lt_selftest,
  output logic               arb_selfver,
  output logic               arb_takeover,
  output logic               resume,
  output logic               err,
  output logic [N_UNITS-1:0] unit_usable
);

  rmc_state_e state_q, state_d;
  rmc_cmd_t   cmd_q;
  logic       mode_q;
  logic       expired;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_D_RUN: begin
        if (perm_fault)                             state_d = ST_D_TAKE;
        else if (arb_req)                           state_d = ST_D_HALT;
        else if (mode_sw_req && mode_sw_to_triple)  state_d = ST_T_RUN;
      end
      ST_D_HALT: begin
        if (phase_done)   state_d = ST_D_COPY;
        else if (expired) state_d = ST_FAULT;
      end
      ST_D_COPY: begin
        if (phase_done)   state_d = ST_D_REEXEC;
        else if (expired) state_d = ST_FAULT;
      end
      ST_D_REEXEC, ST_D_TAKE: begin
        if (phase_done)   state_d = ST_D_RESUME;
        else if (expired) state_d = ST_FAULT;
      end
      ST_D_RESUME: state_d = ST_D_RUN;
      ST_T_RUN: begin
        if (perm_fault)                              state_d = ST_T_VERIFY;
        else if (mode_sw_req && !mode_sw_to_triple)  state_d = ST_D_RUN;
      end
      ST_T_VERIFY: begin
        if (phase_done)   state_d = selfver_pass ? ST_T_CHECK : ST_T_RESUME;
        else if (expired) state_d = ST_FAULT;
      end
      ST_T_CHECK: begin
        if (phase_done)   state_d = ST_T_RESUME;
        else if (expired) state_d = ST_FAULT;
      end
      ST_T_RESUME: state_d = ST_T_RUN;
      ST_FAULT:    state_d = ST_FAULT;
      default:     state_d = ST_FAULT;
    endcase
  end

  rmc_phase_timer #(.LIMIT(TIMEOUT_CYC)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .restart (state_d != state_q),
    .active  (is_waiting(state_q)),
    .expired (expired)
  );

  rmc_unit_table #(.N_UNITS(N_UNITS), .UIDX_W(UIDX_W)) table_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (st_res_valid && is_test_window(state_q)),
    .wr_idx (st_res_unit),
    .wr_bad (st_res_bad),
    .usable (unit_usable)
  );

  // outputs registered from the next-state decode: aligned with state_q
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_D_RUN;
      cmd_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_of(state_d);
      if (state_d != ST_FAULT) mode_q <= is_voting(state_d);
    end
  end

  assign mode_triple  = mode_q;
  assign halt_job     = cmd_q.halt_job;
  assign halt_all     = cmd_q.halt_all;
  assign copy_state   = cmd_q.copy_state;
  assign reexec       = cmd_q.reexec;
  assign lt_recover   = cmd_q.lt_recover;
  assign lt_selftest  = cmd_q.lt_selftest;
  assign arb_selfver  = cmd_q.arb_selfver;
  assign arb_takeover = cmd_q.arb_takeover;
  assign resume       = cmd_q.resume;
  assign err          = cmd_q.err;

endmodule

// File: rtl/redund_mode_ctrl_chk.sv
module redund_mode_ctrl_chk #(
  parameter int N_UNITS = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               arb_req,
  input logic               perm_fault,
  input logic               st_res_valid,
  input logic               mode_triple,
  input logic               halt_job,
  input logic               halt_all,
  input logic               copy_state,
  input logic               reexec,
  input logic               lt_recover,
  input logic               lt_selftest,
  input logic               arb_selfver,
  input logic               arb_takeover,
  input logic               resume,
  input logic               err,
  input logic [N_UNITS-1:0] unit_usable
);

  // R11
  resume_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resume |=> !resume);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !(halt_job || halt_all || copy_state || reexec || lt_recover ||
              lt_selftest || arb_selfver || arb_takeover || resume));

  // R9
  table_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !st_res_valid |=> $stable(unit_usable));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (halt_job || halt_all || lt_selftest || resume || err) |=> $stable(mode_triple));

  // R6
  voting_no_arb_chk: assert property (@(posedge clk) disable iff (rst)
    mode_triple |-> !(halt_job || copy_state || reexec));

  // R2
  copy_needs_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (copy_state || reexec) |-> halt_job);

  // R10
  pf_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_triple && !halt_job && !resume && !err && perm_fault && arb_req)
      |=> (arb_takeover && lt_selftest && !copy_state));

endmodule

bind redund_mode_ctrl redund_mode_ctrl_chk #(.N_UNITS(N_UNITS)) chk_i (.*);

// File: tb/redund_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module redund_mode_ctrl_tb_top;
  localparam int NU = 8;
  localparam int TO = 12;

  localparam logic [10:0] M_MODE = 11'h400, M_HJ = 11'h200, M_HA = 11'h100,
                          M_CP = 11'h080, M_RX = 11'h040, M_LR = 11'h020,
                          M_LS = 11'h010, M_AV = 11'h008, M_AT = 11'h004,
                          M_RS = 11'h002, M_ER = 11'h001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sw_req = 0, mode_sw_to_triple = 0, arb_req = 0, perm_fault = 0;
  logic phase_done = 0, selfver_pass = 0, st_res_valid = 0, st_res_bad = 0;
  logic [2:0] st_res_unit = '0;
  logic mode_triple, halt_job, halt_all, copy_state, reexec, lt_recover;
  logic lt_selftest, arb_selfver, arb_takeover, resume, err;
  logic [NU-1:0] unit_usable;
  logic [10:0] cmd;
  logic [NU-1:0] exp_tab;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  redund_mode_ctrl #(.N_UNITS(NU), .TIMEOUT_CYC(TO)) dut_i (.*);

  assign cmd = {mode_triple, halt_job, halt_all, copy_state, reexec, lt_recover,
                lt_selftest, arb_selfver, arb_takeover, resume, err};

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // hold current phase d cycles (checking it), then handshake
  task automatic stage(int d, logic [10:0] exp_now, string req);
    for (int i = 0; i < d; i++) begin cyc(); chk(req, cmd, exp_now); end
    phase_done = 1; cyc(); phase_done = 0;
  endtask

  task automatic strobe(int u, logic bad);
    st_res_valid = 1; st_res_unit = 3'(u); st_res_bad = bad;
    cyc(); st_res_valid = 0;
  endtask

  initial begin
    repeat (3) cyc();
    rst = 0; cyc();
    chk("R1", cmd, 0); chk("R1", unit_usable, 8'hFF);
    exp_tab = 8'hFF;

    // R2 mismatch path with varied handshake delays, R11 resume width
    for (int d = 0; d < 3; d++) begin
      arb_req = 1; cyc(); arb_req = 0; chk("R2", cmd, M_HJ);
      stage(d, M_HJ, "R2"); chk("R2", cmd, M_HJ | M_CP);
      stage(d, M_HJ | M_CP, "R2"); chk("R2", cmd, M_HJ | M_RX | M_LR);
      stage(d, M_HJ | M_RX | M_LR, "R2"); chk("R11", cmd, M_RS);
      cyc(); chk("R11", cmd, 0);
    end

    // R3 + R10 priority: perm_fault with arb_req and mode switch together
    perm_fault = 1; arb_req = 1; mode_sw_req = 1; mode_sw_to_triple = 1;
    cyc(); perm_fault = 0; arb_req = 0; mode_sw_req = 0;
    chk("R10", cmd, M_HJ | M_AT | M_LS);
    strobe(3, 1); exp_tab[3] = 0; chk("R9", unit_usable, exp_tab);
    stage(1, M_HJ | M_AT | M_LS, "R3"); chk("R3", cmd, M_RS);
    cyc(); chk("R3", cmd, 0);

    // R9 strobe outside a window ignored
    strobe(5, 1); chk("R9", unit_usable, exp_tab);
    strobe(3, 0); chk("R9", unit_usable, exp_tab);

    // R7 switch to voting
    mode_sw_req = 1; mode_sw_to_triple = 1; cyc(); mode_sw_req = 0;
    chk("R7", cmd, M_MODE);
    // R6 arb_req ignored in voting
    arb_req = 1; cyc(); cyc(); arb_req = 0; chk("R6", cmd, M_MODE);

    // R4 verify pass path, table sweep over every unit
    for (int u = 0; u < NU; u++) begin
      perm_fault = 1; cyc(); perm_fault = 0; chk("R4", cmd, M_MODE | M_HA | M_AV);
      strobe(u, 1); exp_tab[u] = 0; chk("R9", unit_usable, exp_tab);
      selfver_pass = 1; stage(0, 0, "R4"); selfver_pass = 0;
      chk("R4", cmd, M_MODE | M_AT | M_LS);
      strobe(u, 0); exp_tab[u] = 1; chk("R9", unit_usable, exp_tab);
      stage(u % 3, M_MODE | M_AT | M_LS, "R4"); chk("R4", cmd, M_MODE | M_RS);
      cyc(); chk("R4", cmd, M_MODE);
    end

    // R5 verify fail path; mode switch inside a phase dropped (R7)
    perm_fault = 1; cyc(); perm_fault = 0; chk("R5", cmd, M_MODE | M_HA | M_AV);
    strobe(0, 1); exp_tab[0] = 0;
    mode_sw_req = 1; mode_sw_to_triple = 0; cyc(); mode_sw_req = 0;
    chk("R7", cmd, M_MODE | M_HA | M_AV);
    selfver_pass = 0; stage(0, 0, "R5"); chk("R5", cmd, M_MODE | M_RS);
    cyc(); chk("R7", cmd, M_MODE); chk("R9", unit_usable, exp_tab);

    // back to paired
    mode_sw_req = 1; mode_sw_to_triple = 0; cyc(); mode_sw_req = 0;
    chk("R7", cmd, 0);

    // R8 handshake on last allowed cycle still advances
    arb_req = 1; cyc(); arb_req = 0; chk("R8", cmd, M_HJ);
    stage(TO - 1, M_HJ, "R8"); chk("R8", cmd, M_HJ | M_CP);
    stage(0, 0, "R8"); stage(0, 0, "R8"); cyc(); chk("R8", cmd, 0);

    // R8 timeout with no handshake
    arb_req = 1; cyc(); arb_req = 0; chk("R8", cmd, M_HJ);
    for (int i = 0; i < TO - 1; i++) begin cyc(); chk("R8", cmd, M_HJ); end
    cyc(); chk("R8", cmd, M_ER);
    arb_req = 1; perm_fault = 1; phase_done = 1; cyc(); cyc();
    arb_req = 0; perm_fault = 0; phase_done = 0;
    chk("R8", cmd, M_ER);

    // R1 reset clears fault and table
    rst = 1; cyc(); rst = 0; cyc();
    chk("R1", cmd, 0); chk("R1", unit_usable, 8'hFF);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule